// File: doc/BRIEF.md
# Power-Management Event Status/Enable Block with SCI

This block holds the event status and event enable registers of a power-management unit and drives the system control interrupt (SCI) from them. Software reaches the two registers through a 64-byte I/O window. The window base comes from a configuration value, and the window is switched on by a configuration control bit. Hardware raises events with one-cycle pulses on a 16-bit event bus, and each pulse latches a status bit. Software acknowledges an event by writing a 1 to its status bit.

The SCI is a level output. It is driven only by four event classes: the timer overflow, the global lock, the power button and the RTC alarm. An event counts toward the SCI only when its status bit and its enable bit are both set. The block also gives the external PM timer a request to arm its overflow event. That request stands while the timer event is enabled and its status is not already pending.

Top module: `pm_event_sci`

## Requirements
- R1: After reset the status register, the enable register, `sci` and `tmr_arm` are all 0. The configuration base is 0 and the window is disabled, so `io_hit` is 0 and `io_rdata` is 0.
- R2: Configuration bytes 0x40 (low) and 0x41 (high) form the 16-bit window base, little-endian. Only address bits 15:6 of that base are compared. `io_hit` is 1 exactly when the window is enabled and `io_addr[15:6]` equals those base bits.
- R3: The window is enabled by bit 0 of configuration byte 0x80. While that bit is 0, no I/O access hits, I/O writes change no register, and `io_rdata` is 0.
- R4: Inside the window, the offset is `io_addr[5:0]` and bit 0 of the offset is ignored. Offsets 0x00/0x01 read the status register and offsets 0x02/0x03 read the enable register. All other offsets read 0, and writes to them are ignored.
- R5: A 1 on `evt[i]` in a cycle sets status bit i at that clock edge. The bit stays set until software clears it.
- R6: An I/O write to the status register clears every status bit whose data bit is 1 in an enabled byte lane. `io_be[0]` covers bits 7:0 and `io_be[1]` covers bits 15:8. Data bits that are 0 leave the status unchanged. An event and a clear of the same bit in the same cycle leave the bit set.
- R7: An I/O write to the enable register replaces the bytes selected by `io_be` and keeps the other bytes.
- R8: `sci` is registered. At each clock edge it takes the OR of (status AND enable) over bits 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC alarm), so it follows any change one cycle later. No other bit ever raises `sci`.
- R9: `tmr_arm` is 1 exactly when enable bit 0 is 1 and status bit 0 is 0. It follows the current register contents with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | I/O write strobe |
| io_be | input | 2 | I/O byte-lane enables |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data for the current address |
| io_hit | output | 1 | Current address falls in the enabled window |
| evt | input | 16 | One-cycle event pulses, one per status bit |
| sci | output | 1 | Level-sensitive system control interrupt |
| tmr_arm | output | 1 | Request to arm the PM timer overflow event |

## Verification
The assertions assume that reset is held for at least one clock edge, and that every event pulse and I/O write is valid for a whole cycle at a rising edge. They do not depend on how long a pulse on `evt` lasts, so a level held for several cycles is also legal. The stimulus changes all inputs only on the falling clock edge. It mixes window-internal and window-external addresses, arbitrary byte lanes and sparse single-bit events, and it toggles the window enable now and then. Each outcome is compared with a bench-side register model.

// File: rtl/pm_event_sci.sv
module pm_event_sci #(
  parameter int ADDR_W   = 16,
  parameter int REG_W    = 16,
  parameter int WIN_LOG2 = 6,
  parameter int TMR_BIT  = 0,
  parameter logic [REG_W-1:0] SCI_MASK = 16'h0521
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [REG_W/8-1:0] io_be,
  input  logic [REG_W-1:0]  io_wdata,
  output logic [REG_W-1:0]  io_rdata,
  output logic              io_hit,
  input  logic [REG_W-1:0]  evt,
  output logic              sci,
  output logic              tmr_arm
);
  localparam int NLANE = REG_W / 8;
  localparam int NBASE = ADDR_W / 8;
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((1 << WIN_LOG2) - 1);
  localparam logic [7:0] CFG_BASE = 8'h40;
  localparam logic [7:0] CFG_CTL  = 8'h80;

  logic [ADDR_W-1:0] cfg_base_q;
  logic              win_en_q;
  logic [REG_W-1:0]  sts_q, en_q, lane_mask, clr;
  logic              sel_sts, sel_en;

  genvar b;
  generate
    for (b = 0; b < NBASE; b++) begin : g_base
      always_ff @(posedge clk)
        if (!rst_n)
          cfg_base_q[8*b +: 8] <= 8'h00;
        else if (cfg_wr && cfg_addr == CFG_BASE + 8'(b))
          cfg_base_q[8*b +: 8] <= cfg_wdata;
    end
    for (b = 0; b < NLANE; b++) begin : g_lane
      assign lane_mask[8*b +: 8] = {8{io_be[b]}};
    end
  endgenerate

  always_ff @(posedge clk)
    if (!rst_n)
      win_en_q <= 1'b0;
    else if (cfg_wr && cfg_addr == CFG_CTL)
      win_en_q <= cfg_wdata[0];

  assign io_hit  = win_en_q && ((io_addr & ~OFS_MASK) == (cfg_base_q & ~OFS_MASK));
  assign sel_sts = io_hit && io_addr[WIN_LOG2-1:1] == '0;
  assign sel_en  = io_hit && io_addr[WIN_LOG2-1:1] == (WIN_LOG2-1)'(1);
  assign clr     = (io_wr && sel_sts) ? (io_wdata & lane_mask) : '0;

  always_ff @(posedge clk)
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      sci   <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr) | evt;
      if (io_wr && sel_en)
        en_q <= (en_q & ~lane_mask) | (io_wdata & lane_mask);
      sci <= |(sts_q & en_q & SCI_MASK);
    end

  assign tmr_arm  = en_q[TMR_BIT] & ~sts_q[TMR_BIT];
  assign io_rdata = sel_sts ? sts_q : (sel_en ? en_q : '0);
endmodule

// File: rtl/pm_event_sci_chk.sv
module pm_event_sci_chk #(
  parameter int REG_W   = 16,
  parameter int TMR_BIT = 0,
  parameter logic [REG_W-1:0] SCI_MASK = 16'h0521
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] evt,
  input logic [REG_W-1:0] sts,
  input logic [REG_W-1:0] en,
  input logic             win_en,
  input logic             io_hit,
  input logic             io_wr,
  input logic             sci,
  input logic             tmr_arm
);
  a_r5_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((sts & $past(evt)) == $past(evt)));

  a_r3_window_off: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !io_hit);

  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(io_wr && io_hit) && evt == '0) |=> ($stable(sts) && $stable(en)));

  a_r8_sci_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & en & SCI_MASK) == '0) |=> !sci);

  a_r8_sci_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & en & SCI_MASK) != '0) |=> sci);

  a_r9_arm_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    sts[TMR_BIT] |-> !tmr_arm);
endmodule

bind pm_event_sci pm_event_sci_chk #(.REG_W(REG_W), .TMR_BIT(TMR_BIT), .SCI_MASK(SCI_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .sts(sts_q), .en(en_q), .win_en(win_en_q),
  .io_hit(io_hit), .io_wr(io_wr), .sci(sci), .tmr_arm(tmr_arm)
);

// File: tb/sim_pm_event_sci.sv
module sim_pm_event_sci;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0; logic [7:0] cfg_addr = 0, cfg_wdata = 0;
  logic [15:0] io_addr = 0, io_wdata = 0, evt = 0;
  logic io_wr = 0; logic [1:0] io_be = 0;
  logic [15:0] io_rdata; logic io_hit, sci, tmr_arm;

  pm_event_sci u0 (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .io_addr(io_addr), .io_wr(io_wr), .io_be(io_be),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit), .evt(evt),
    .sci(sci), .tmr_arm(tmr_arm));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] m_sts = 0, m_en = 0, m_base = 0;
  logic m_win = 0, m_sci = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit f_hit(logic [15:0] a);
    return m_win && a[15:6] == m_base[15:6];
  endfunction

  function automatic logic [15:0] f_rd(logic [15:0] a);
    if (!f_hit(a)) return 16'h0;
    if (a[5:1] == 5'd0) return m_sts;
    if (a[5:1] == 5'd1) return m_en;
    return 16'h0;
  endfunction

  task automatic cyc(bit wr, logic [15:0] a, logic [1:0] be, logic [15:0] wd,
                     logic [15:0] ev, bit cw = 0, logic [7:0] ca = 0, logic [7:0] cd = 0);
    logic [15:0] lm, n_sts, n_en, n_base; logic n_win, n_sci;
    @(negedge clk);
    io_wr = wr; io_addr = a; io_be = be; io_wdata = wd; evt = ev;
    cfg_wr = cw; cfg_addr = ca; cfg_wdata = cd;
    #1;
    chk("R2 io_hit", {15'b0, io_hit}, {15'b0, f_hit(a)});
    chk("R4 io_rdata", io_rdata, f_rd(a));
    lm = {{8{be[1]}}, {8{be[0]}}};
    n_sts = m_sts; n_en = m_en; n_base = m_base; n_win = m_win;
    if (wr && f_hit(a) && a[5:1] == 5'd0) n_sts = n_sts & ~(wd & lm);
    n_sts = n_sts | ev;
    if (wr && f_hit(a) && a[5:1] == 5'd1) n_en = (m_en & ~lm) | (wd & lm);
    n_sci = |(m_sts & m_en & 16'h0521);
    if (cw && ca == 8'h40) n_base[7:0] = cd;
    if (cw && ca == 8'h41) n_base[15:8] = cd;
    if (cw && ca == 8'h80) n_win = cd[0];
    @(posedge clk); #1;
    m_sts = n_sts; m_en = n_en; m_base = n_base; m_win = n_win; m_sci = n_sci;
    io_wr = 0; evt = 0; cfg_wr = 0;
    chk("R8 sci", {15'b0, sci}, {15'b0, m_sci});
    chk("R9 tmr_arm", {15'b0, tmr_arm}, {15'b0, m_en[0] & ~m_sts[0]});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog R1..R9 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R1 reset state
    chk("R1 sci", {15'b0, sci}, 16'h0);
    chk("R1 tmr_arm", {15'b0, tmr_arm}, 16'h0);
    chk("R1 io_hit", {15'b0, io_hit}, 16'h0);
    chk("R1 io_rdata", io_rdata, 16'h0);
    // R3 write with window disabled is dropped
    cyc(1, 16'h0002, 2'b11, 16'hFFFF, 0);
    cyc(0, 0, 0, 0, 0, 1, 8'h80, 8'h01);
    cyc(0, 16'h0002, 2'b11, 0, 0);
    chk("R3 write ignored while off", io_rdata, 16'h0000);
    // R2 base from 0x40/0x41, low 6 bits masked
    cyc(0, 0, 0, 0, 0, 1, 8'h40, 8'h78);
    cyc(0, 0, 0, 0, 0, 1, 8'h41, 8'h56);
    cyc(0, 16'h567F, 0, 0, 0);
    chk("R2 last offset hits", {15'b0, io_hit}, 16'h1);
    cyc(0, 16'h5680, 0, 0, 0);
    chk("R2 past window misses", {15'b0, io_hit}, 16'h0);
    cyc(0, 16'h563F, 0, 0, 0);
    chk("R2 below window misses", {15'b0, io_hit}, 16'h0);
    // R7 enable writes by lane
    cyc(1, 16'h5642, 2'b11, 16'h0523, 0);
    cyc(0, 16'h5643, 0, 0, 0);
    chk("R7 full write", io_rdata, 16'h0523);
    cyc(1, 16'h5642, 2'b01, 16'hFFFF, 0);
    cyc(0, 16'h5642, 0, 0, 0);
    chk("R7 low lane only", io_rdata, 16'h05FF);
    cyc(1, 16'h5642, 2'b11, 16'h0522, 0);
    // R4 unused offset
    cyc(1, 16'h5644, 2'b11, 16'hFFFF, 0);
    cyc(0, 16'h5644, 0, 0, 0);
    chk("R4 unused offset reads 0", io_rdata, 16'h0);
    // R5 / R8 non-SCI bit set and enabled
    cyc(0, 16'h5640, 0, 0, 16'h0002);
    cyc(0, 16'h5640, 0, 0, 0);
    chk("R5 status bit1", io_rdata, 16'h0002);
    chk("R8 bit1 no sci", {15'b0, sci}, 16'h0);
    // R8 power button, one-cycle lag
    cyc(0, 16'h5640, 0, 0, 16'h0100);
    chk("R8 sci not yet", {15'b0, sci}, 16'h0);
    cyc(0, 16'h5640, 0, 0, 0);
    chk("R8 sci raised", {15'b0, sci}, 16'h1);
    // R6 write-0 no effect, set beats clear, clear works
    cyc(1, 16'h5640, 2'b11, 16'h0000, 0);
    cyc(0, 16'h5640, 0, 0, 0);
    chk("R6 write zero keeps", io_rdata, 16'h0102);
    cyc(1, 16'h5641, 2'b10, 16'h0100, 16'h0100);
    cyc(0, 16'h5640, 0, 0, 0);
    chk("R6 event wins", io_rdata, 16'h0102);
    cyc(1, 16'h5640, 2'b01, 16'hFFFF, 0);
    cyc(0, 16'h5640, 0, 0, 0);
    chk("R6 lane masked clear", io_rdata, 16'h0100);
    cyc(1, 16'h5640, 2'b10, 16'h0100, 0);
    cyc(0, 16'h5640, 0, 0, 0);
    cyc(0, 16'h5640, 0, 0, 0);
    chk("R6 cleared", io_rdata, 16'h0000);
    chk("R8 sci dropped", {15'b0, sci}, 16'h0);
    // R9 timer arm
    cyc(1, 16'h5642, 2'b01, 16'h0001, 0);
    chk("R9 arm on", {15'b0, tmr_arm}, 16'h1);
    cyc(0, 16'h5640, 0, 0, 16'h0001);
    chk("R9 arm off when pending", {15'b0, tmr_arm}, 16'h0);
    cyc(0, 16'h5640, 0, 0, 0);
    chk("R8 timer sci", {15'b0, sci}, 16'h1);
    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [15:0] ev;
      ev = ($urandom % 4 == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      if ($urandom % 60 == 0)
        cyc(0, 16'h5640, 0, 0, ev, 1, 8'h80, 8'($urandom % 2));
      else
        cyc($urandom % 2, 16'h5640 + 16'($urandom % 72), 2'($urandom),
            16'($urandom), ev);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule